// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block arbitrates the interrupt sources of a 16550-style serial port. It looks at the interrupt-enable register, the line status byte, the receive FIFO fill level against its trigger level, a character-timeout pending flag, a transmit-holding-empty pending latch and the modem-status delta bits. From these it forms the interrupt identification byte that software reads and a single level-sensitive interrupt line.

The transmit-empty source is held in its own pending latch and is not a live status bit. The transmitter sets the latch when the holding register drains. A write to the holding register clears it, and so does a read of the identification byte while that byte reports transmit-empty. Any write to the enable register that toggles the transmit-empty enable re-samples the latch. The enable register and the latch are the only state in the block. The identification byte and the interrupt line are formed from them and from the live inputs without further registers, so a register access that changes the state shows at the outputs one cycle later.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the pending latch is clear, the identification low nibble is 0x1 and irq_o is 0.
- R2: When several sources are active and enabled, the reported source follows this priority, highest first: line status, character timeout, received data, transmit empty, modem status.
- R3: The line status source (ID 0x6) is active when enable bit 2 is set and lsr_i & 0x1E is nonzero. Data-ready (bit 0) and bit 7 of lsr_i do not raise it.
- R4: The character-timeout source (ID 0xC) is active when rx_timeout_i is 1 and enable bit 0 is set. With bit 0 clear it is masked.
- R5: The received-data source (ID 0x4) needs enable bit 0 and lsr_i bit 0. With fifo_en_i=1 it also needs rx_count_i >= rx_level_i. With fifo_en_i=0, data-ready alone is enough.
- R6: An iir_rd_i pulse while the low nibble reports 0x2 clears the pending latch. A read while the nibble reports any other source leaves the latch unchanged.
- R7: A write to the enable register that changes bit 1 sets the latch if the new bit 1 is 1 and thr_empty_i is 1, and clears it otherwise. A write that leaves bit 1 unchanged does not touch the latch.
- R8: Only bits 3:0 of ier_wdata_i are stored. ier_o returns them.
- R9: iir_o[7:6] read 11 when fifo_en_i is 1 and 00 otherwise. iir_o[5:4] are always 0.
- R10: irq_o is 1 exactly when the identification low nibble differs from 0x1.
- R11: thr_wr_i clears the latch and thre_set_i sets it. When events coincide, an enable write that changes bit 1 wins, then thr_wr_i, then thre_set_i, then the read clear.
- R12: The modem source (ID 0x0) is active when enable bit 3 is set and any bit of msr_delta_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| thre_set_i | input | 1 | Holding register became empty |
| thr_empty_i | input | 1 | Holding register empty status |
| fifo_en_i | input | 1 | FIFO mode enabled |
| lsr_i | input | 8 | Line status byte |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_level_i | input | CNT_W | Receive trigger level in bytes |
| rx_timeout_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Stored enable bits |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong pending latch shows as a 0x2 that appears or is missing in the identification nibble, together with irq_o, in the cycle after the access that should have changed it. The bench samples at exactly that cycle after each enable write, holding write, empty event and identification read. A fault in the source qualification or the priority encoder shows immediately as a wrong nibble for a fixed set of inputs. Table vectors that stack several sources at once expose a wrong priority order.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  // source index doubles as priority rank, 0 highest
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MODEM   = 4;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  localparam logic [7:0] LSR_ERR_MASK = 8'h1E;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LINE:    src_code = ID_LINE;
      SRC_TIMEOUT: src_code = ID_TIMEOUT;
      SRC_RXDATA:  src_code = ID_RXDATA;
      SRC_THRE:    src_code = ID_THRE;
      default:     src_code = ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ier_we_i,
  input  logic [3:0] ier_wdata_i,
  input  logic       iir_rd_i,
  input  logic       id_is_thre_i,
  input  logic       thr_wr_i,
  input  logic       thre_set_i,
  input  logic       thr_empty_i,
  output logic [3:0] ier_o,
  output logic       thre_pend_o
);
  logic [3:0] ier_q;
  logic       pend_q, pend_d, en_toggle;

  assign en_toggle = ier_we_i && (ier_wdata_i[EN_THRE] != ier_q[EN_THRE]);

  always_comb begin
    pend_d = pend_q;
    if (en_toggle)                      pend_d = ier_wdata_i[EN_THRE] & thr_empty_i;
    else if (thr_wr_i)                  pend_d = 1'b0;
    else if (thre_set_i)                pend_d = 1'b1;
    else if (iir_rd_i && id_is_thre_i)  pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ier_we_i) ier_q <= ier_wdata_i;
      pend_q <= pend_d;
    end
  end

  assign ier_o       = ier_q;
  assign thre_pend_o = pend_q;

  // R7
  ier_toggle_resample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && (ier_wdata_i[EN_THRE] != ier_o[EN_THRE]))
      |=> (thre_pend_o == ($past(ier_wdata_i[EN_THRE]) && $past(thr_empty_i))));
  // R6
  id_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && id_is_thre_i && !ier_we_i && !thr_wr_i && !thre_set_i) |=> !thre_pend_o);
  // R11
  thr_write_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !ier_we_i) |=> !thre_pend_o);
  // R8
  ier_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> (ier_o == $past(ier_wdata_i)));
endmodule

// File: rtl/uart_irq_qualify.sv
module uart_irq_qualify
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]         ier_i,
  input  logic               fifo_en_i,
  input  logic [7:0]         lsr_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   rx_level_i,
  input  logic               rx_timeout_i,
  input  logic               thre_pend_i,
  input  logic [3:0]         msr_delta_i,
  output logic [NUM_SRC-1:0] req_o
);
  logic rx_ready;

  // in FIFO mode data must also reach the trigger level
  assign rx_ready = lsr_i[0] && (!fifo_en_i || (rx_count_i >= rx_level_i));

  always_comb begin
    req_o              = '0;
    req_o[SRC_LINE]    = ier_i[EN_LINE]  && |(lsr_i & LSR_ERR_MASK);
    req_o[SRC_TIMEOUT] = ier_i[EN_RX]    && rx_timeout_i;
    req_o[SRC_RXDATA]  = ier_i[EN_RX]    && rx_ready;
    req_o[SRC_THRE]    = ier_i[EN_THRE]  && thre_pend_i;
    req_o[SRC_MODEM]   = ier_i[EN_MODEM] && |msr_delta_i;
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [3:0]   id_o,
  output logic         irq_o
);
  logic [N-1:0] blocked, grant;

  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign blocked[i] = 1'b0;
    end else begin : g_low
      assign blocked[i] = blocked[i-1] | req_i[i-1];
    end
    assign grant[i] = req_i[i] & ~blocked[i];
  end

  always_comb begin
    id_o = ID_NONE;
    for (int i = 0; i < N; i++)
      if (grant[i]) id_o = src_code(i);
  end

  assign irq_o = |req_i;

  // R2
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant));
  // R10
  irq_id_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (id_o != ID_NONE));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  input  logic             thre_set_i,
  input  logic             thr_empty_i,
  input  logic             fifo_en_i,
  input  logic [7:0]       lsr_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic             rx_timeout_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       ier_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [NUM_SRC-1:0] req;
  logic [3:0]         id;
  logic               thre_pend;

  uart_irq_enable u_enable (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_we_i     (ier_we_i),
    .ier_wdata_i  (ier_wdata_i[3:0]),
    .iir_rd_i     (iir_rd_i),
    .id_is_thre_i (id == ID_THRE),
    .thr_wr_i     (thr_wr_i),
    .thre_set_i   (thre_set_i),
    .thr_empty_i  (thr_empty_i),
    .ier_o        (ier_o),
    .thre_pend_o  (thre_pend)
  );

  uart_irq_qualify #(.CNT_W(CNT_W)) u_qualify (
    .ier_i        (ier_o),
    .fifo_en_i    (fifo_en_i),
    .lsr_i        (lsr_i),
    .rx_count_i   (rx_count_i),
    .rx_level_i   (rx_level_i),
    .rx_timeout_i (rx_timeout_i),
    .thre_pend_i  (thre_pend),
    .msr_delta_i  (msr_delta_i),
    .req_o        (req)
  );

  uart_irq_arbiter #(.N(NUM_SRC)) u_arbiter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .id_o   (id),
    .irq_o  (irq_o)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, id};

  // R3
  line_needs_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[3:0] == ID_LINE) |-> (ier_o[EN_LINE] && |(lsr_i & LSR_ERR_MASK)));
  // R4
  timeout_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_o[EN_RX] |-> (iir_o[3:0] != ID_TIMEOUT));
  // R9
  fifo_flag_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[7:4] == (fifo_en_i ? 4'hC : 4'h0)));
  // R10
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != ID_NONE));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_we = 0, iir_rd = 0, thr_wr = 0, thre_set = 0, thr_empty = 0, fifo_en = 0, tmo = 0;
  logic [7:0] ier_wd = 0, lsr = 0;
  logic [CW-1:0] cnt = 0, lvl = 0;
  logic [3:0] msr = 0, ier_rb;
  logic [7:0] iir;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_irq_ident dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_we_i(ier_we), .ier_wdata_i(ier_wd),
    .iir_rd_i(iir_rd), .thr_wr_i(thr_wr), .thre_set_i(thre_set), .thr_empty_i(thr_empty),
    .fifo_en_i(fifo_en), .lsr_i(lsr), .rx_count_i(cnt), .rx_level_i(lvl),
    .rx_timeout_i(tmo), .msr_delta_i(msr), .ier_o(ier_rb), .iir_o(iir), .irq_o(irq));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  // drive at a falling edge; state is visible at the next falling edge
  task automatic write_ier(input logic [7:0] v);
    @(negedge clk); ier_we = 1; ier_wd = v;
    @(negedge clk); ier_we = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); iir_rd = 1;
    @(negedge clk); iir_rd = 0;
  endtask

  // {ier, fifo_en, lsr, count, level, timeout, msr_delta, expected iir, req tag}
  localparam logic [39:0] VEC [15] = '{
    {4'h4, 1'b0, 8'h02, 5'd0,  5'd0,  1'b0, 4'h0, 8'h06, 4'd3},  // R3 R9
    {4'h0, 1'b0, 8'h02, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01, 4'd3},  // R3 masked
    {4'h4, 1'b0, 8'h01, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01, 4'd3},  // R3 DR excluded
    {4'h4, 1'b0, 8'h80, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01, 4'd3},  // R3 bit7 excluded
    {4'h1, 1'b1, 8'h01, 5'd1,  5'd4,  1'b1, 4'h0, 8'hCC, 4'd4},  // R4
    {4'h0, 1'b1, 8'h00, 5'd0,  5'd0,  1'b1, 4'h0, 8'hC1, 4'd4},  // R4 gated
    {4'h1, 1'b1, 8'h01, 5'd3,  5'd4,  1'b0, 4'h0, 8'hC1, 4'd5},  // R5 below level
    {4'h1, 1'b1, 8'h01, 5'd4,  5'd4,  1'b0, 4'h0, 8'hC4, 4'd5},  // R5 at level
    {4'h1, 1'b0, 8'h01, 5'd0,  5'd14, 1'b0, 4'h0, 8'h04, 4'd5},  // R5 no fifo
    {4'h8, 1'b0, 8'h00, 5'd0,  5'd0,  1'b0, 4'h4, 8'h00, 4'd12}, // R12
    {4'h8, 1'b0, 8'h00, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01, 4'd12}, // R12 idle
    {4'hD, 1'b1, 8'h13, 5'd14, 5'd14, 1'b1, 4'h1, 8'hC6, 4'd2},  // R2
    {4'h9, 1'b1, 8'h01, 5'd14, 5'd14, 1'b1, 4'h1, 8'hCC, 4'd2},  // R2
    {4'h9, 1'b1, 8'h01, 5'd14, 5'd14, 1'b0, 4'h1, 8'hC4, 4'd2},  // R2
    {4'h8, 1'b1, 8'h1E, 5'd0,  5'd0,  1'b1, 4'h2, 8'hC0, 4'd2}   // R2
  };

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 iir", iir, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 ier", {4'd0, ier_rb}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 iir after release", iir, 8'h01);

    for (int i = 0; i < 15; i++) begin
      logic [39:0] v;
      v = VEC[i];
      @(negedge clk);
      ier_we = 1; ier_wd = {4'h0, v[39:36]};
      fifo_en = v[35]; lsr = v[34:27]; cnt = v[26:22]; lvl = v[21:17];
      tmo = v[16]; msr = v[15:12];
      @(negedge clk);
      ier_we = 0;
      check($sformatf("R%0d vec%0d iir", v[3:0], i), iir, v[11:4]);
      // R10 irq follows the nibble
      check($sformatf("R10 vec%0d irq", i), {7'd0, irq}, {7'd0, v[7:4] != 4'h1});
    end

    fifo_en = 0; lsr = 0; cnt = 0; lvl = 0; tmo = 0; msr = 0;
    // R8 upper enable bits dropped
    write_ier(8'hF0);
    check("R8 upper dropped", {4'd0, ier_rb}, 8'h00);
    write_ier(8'h00);

    // R7 enabling with holding empty arms the latch
    thr_empty = 1;
    write_ier(8'h02);
    check("R7 arm iir", iir, 8'h02);
    check("R7 arm irq", {7'd0, irq}, 8'h01);
    // R6 read of 0x2 clears
    pulse_rd();
    check("R6 read clear", iir, 8'h01);
    check("R6 read clear irq", {7'd0, irq}, 8'h00);
    // R7 unchanged bit leaves latch
    write_ier(8'h02);
    check("R7 no toggle", iir, 8'h01);
    // R7 toggle with holding full clears/does not arm
    write_ier(8'h00);
    thr_empty = 0;
    write_ier(8'h02);
    check("R7 full no arm", iir, 8'h01);
    // R11 empty event sets, holding write clears
    @(negedge clk); thre_set = 1;
    @(negedge clk); thre_set = 0;
    check("R11 set", iir, 8'h02);
    @(negedge clk); thr_wr = 1;
    @(negedge clk); thr_wr = 0;
    check("R11 clear", iir, 8'h01);
    // R11 coincident write beats empty event
    @(negedge clk); thr_wr = 1; thre_set = 1;
    @(negedge clk); thr_wr = 0; thre_set = 0;
    check("R11 write wins", iir, 8'h01);
    // R6 read while a higher source shows leaves latch
    @(negedge clk); thre_set = 1;
    @(negedge clk); thre_set = 0;
    write_ier(8'h06);
    lsr = 8'h08;
    @(negedge clk);
    check("R6 line shown", iir, 8'h06);
    pulse_rd();
    lsr = 8'h00;
    @(negedge clk);
    check("R6 latch kept", iir, 8'h02);
    // R7 disabling the enable clears the latch
    write_ier(8'h04);
    write_ier(8'h06);
    check("R7 disable cleared", iir, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule